// File: doc/BRIEF.md
# Dual ADC Conversion Sequencer

This block sequences two analog-to-digital conversion engines through a small word-addressed register interface. Each engine owns a 16-bit channel mask and, once a request is accepted, scans the enabled channels one at a time in ascending order. For each channel it drives a start pulse and a channel number onto an abstract converter port. It then waits for the converter's done pulse and latches the result. After the last enabled channel it raises a per-engine end-of-scan flag, which can drive an interrupt line.

Requests come from a software start bit or from an external trigger pulse, which is already qualified before it reaches the block. Both kinds set the engine's start bit. Hardware clears that bit when the scan ends. In independent mode the two engines run on their own triggers and flags. In simultaneous mode the first engine's request runs the first engine's scan and then the second engine's scan. At the end of that sequence only the first engine's flag is raised. The analog converter is outside the block.

Top module: `adc_scan_seq`

## Requirements
- R1: Register word 0 holds the channel masks: engine 0 uses bits 15:0 and engine 1 uses bits 31:16. The word reads back exactly what was last written. Word 1 is control, word 2 is status and word 3 holds the latest results (engine 0 in bits 11:0, engine 1 in bits 27:16).
- R2: Control bit 0 enables the converter. While it is 0, triggers and start writes are not accepted and no conversion starts. Writing it to 0 aborts any running scan: busy and both start bits read 0 on the next cycle.
- R3: Control bit 3 is engine 0's start bit and bit 11 is engine 1's. A start bit is set by a trigger pulse, or by writing 1 to it while the block is enabled. Writing 0 has no effect. The bit reads 1 until the request's scan ends and then clears by itself.
- R4: An accepted request starts the scan on the next cycle. The engine converts the enabled channels in ascending order, with one start pulse per channel and the channel number on the converter port. The next start follows one cycle after each done. While a scan runs, status shows busy (bit 3 / bit 11) and the current channel (bits 7:4 / 15:12). Word 3 shows the last result.
- R5: Status bit 0 (engine 0) and bit 8 (engine 1) are the end flags. A flag is set in the cycle after the last channel's done. Writing 1 to the bit clears it, and a set in the same cycle wins. Status bit 23 / bit 31 are the end-of-scan bits: each is set when its engine's scan ends and cleared when a new request is accepted.
- R6: Each engine's interrupt output equals its flag ANDed with its interrupt enable: control bit 1 for engine 0 and bit 9 for engine 1.
- R7: A trigger or start write that arrives while the engine's request is pending or its scan is running causes no second scan.
- R8: A request on an engine whose mask is empty clears the start bit one cycle later. No conversion runs, and neither the flag nor the end-of-scan bit is set.
- R9: When control bits 7:6 are 10 or 11 (simultaneous mode), engine 0's request runs engine 0's scan and then engine 1's scan. Only engine 0's flag is set, at the end of engine 1's scan. Engine 1's trigger and its start write are ignored. Engine 0's start bit stays set until the whole sequence ends.
- R10: When control bits 7:6 are 00 or 01, the two engines run independently, each on its own trigger and with its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| trig_i | input | 2 | Qualified trigger pulse per engine |
| conv_start_o | output | 2 | Converter start pulse per engine |
| conv_ch_o | output | 8 | Channel number per engine (4 bits each) |
| conv_done_i | input | 2 | Converter done pulse per engine |
| conv_data_i | input | 24 | Converter result per engine (12 bits each) |
| irq_o | output | 2 | Interrupt request per engine |

## Verification
Each result has a fixed latency from its stimulus. A trigger or start write at one clock edge makes the start bit readable after that edge. Busy, the channel number and the first converter start pulse follow one edge later. A done pulse sampled at an edge produces either the next start pulse or the flag and end-of-scan update after that same edge, and the interrupt output changes with the flag. The bench holds a behavioural model that it advances at every rising edge from the same inputs the design sees. It compares read data, interrupts, start pulses and channel numbers at every falling edge, so each result is checked in exactly the cycle it becomes due. Scenario checks then compare the recorded channel order, the flags and the results against hand-derived values.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int NCH = 16;
  localparam int CW  = $clog2(NCH);
  localparam int DW  = 12;
  localparam int HW  = 16;

  typedef enum logic [1:0] {
    A_MASK = 2'd0,
    A_CTRL = 2'd1,
    A_STAT = 2'd2,
    A_DATA = 2'd3
  } reg_addr_e;

  // control bit positions
  localparam int C_EN    = 0;
  localparam int C_IE0   = 1;
  localparam int C_ST0   = 3;
  localparam int C_MODE  = 6;
  localparam int C_IE1   = 9;
  localparam int C_ST1   = 11;
  // status bit positions
  localparam int S_FLG0  = 0;
  localparam int S_BSY0  = 3;
  localparam int S_CH0   = 4;
  localparam int S_FLG1  = 8;
  localparam int S_BSY1  = 11;
  localparam int S_CH1   = 12;
  localparam int S_EOC0  = 23;
  localparam int S_EOC1  = 31;
endpackage

// File: rtl/adc_scan_engine.sv
module adc_scan_engine
  import adc_scan_pkg::*;
#(
  parameter int N = NCH,
  parameter int W = DW,
  localparam int CHW = $clog2(N)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           run_i,
  input  logic           req_i,
  input  logic [N-1:0]   mask_i,
  input  logic           conv_done_i,
  input  logic [W-1:0]   conv_data_i,
  output logic           conv_start_o,
  output logic [CHW-1:0] conv_ch_o,
  output logic           busy_o,
  output logic           skip_o,
  output logic           fin_o,
  output logic [W-1:0]   result_o
);
  logic           busy_q, cst_q;
  logic [CHW-1:0] ch_q, first_ch, next_ch;
  logic [N-1:0]   scan_q;
  logic [W-1:0]   res_q;
  logic           has_next, begin_w, step_w;

  // lowest set bit of the live mask, and lowest latched bit above ch_q
  always_comb begin
    first_ch = '0;
    next_ch  = '0;
    has_next = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (mask_i[k]) first_ch = CHW'(k);
      if (scan_q[k] && (k > int'(ch_q))) begin
        next_ch  = CHW'(k);
        has_next = 1'b1;
      end
    end
  end

  assign begin_w = run_i && !busy_q && req_i && (|mask_i);
  assign skip_o  = run_i && !busy_q && req_i && !(|mask_i);
  assign step_w  = run_i && busy_q && conv_done_i;
  assign fin_o   = step_w && !has_next;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cst_q  <= 1'b0;
      ch_q   <= '0;
      scan_q <= '0;
      res_q  <= '0;
    end else if (!run_i) begin
      busy_q <= 1'b0;
      cst_q  <= 1'b0;
    end else begin
      cst_q <= 1'b0;
      if (begin_w) begin
        busy_q <= 1'b1;
        ch_q   <= first_ch;
        scan_q <= mask_i;
        cst_q  <= 1'b1;
      end else if (step_w) begin
        res_q <= conv_data_i;
        if (has_next) begin
          ch_q  <= next_ch;
          cst_q <= 1'b1;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign conv_start_o = cst_q;
  assign conv_ch_o    = ch_q;
  assign busy_o       = busy_q;
  assign result_o     = res_q;

  // R4
  start_in_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> scan_q[conv_ch_o]);
  // R4
  ascending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o) && conv_start_o) |-> (conv_ch_o > $past(conv_ch_o)));
endmodule

// File: rtl/adc_scan_regs.sv
module adc_scan_regs
  import adc_scan_pkg::*;
#(
  parameter int N = NCH,
  parameter int W = DW,
  localparam int CHW = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [31:0]      wdata_i,
  input  logic [1:0]       trig_i,
  input  logic [1:0]       busy_i,
  input  logic [2*CHW-1:0] ch_i,
  input  logic [2*W-1:0]   res_i,
  input  logic [1:0]       skip_i,
  input  logic [1:0]       fin_i,
  output logic             run_o,
  output logic [1:0]       req_o,
  output logic [2*N-1:0]   mask_o,
  output logic [1:0]       irq_o,
  output logic [31:0]      rdata_o
);
  reg_addr_e   addr;
  logic [31:0] mask_q;
  logic        en_q, seq1_q, got0_q;
  logic [1:0]  ie_q, mode_q, start_q, flag_q, eoc_q;
  logic [1:0]  set_st, clr_st, end_w, fset, fclr;
  logic        sim, wr_mask, wr_ctrl, wr_stat;

  assign addr    = reg_addr_e'(addr_i);
  assign sim     = mode_q[1];
  assign wr_mask = we_i && (addr == A_MASK);
  assign wr_ctrl = we_i && (addr == A_CTRL);
  assign wr_stat = we_i && (addr == A_STAT);
  assign end_w   = fin_i | skip_i;

  assign set_st[0] = en_q && (trig_i[0] || (wr_ctrl && wdata_i[C_ST0]));
  assign set_st[1] = sim ? end_w[0] : (en_q && (trig_i[1] || (wr_ctrl && wdata_i[C_ST1])));
  assign clr_st[0] = sim ? end_w[1] : end_w[0];
  assign clr_st[1] = end_w[1];
  assign fset[0]   = sim ? (fin_i[1] || (skip_i[1] && got0_q)) : fin_i[0];
  assign fset[1]   = !sim && fin_i[1];
  assign fclr      = {wr_stat && wdata_i[S_FLG1], wr_stat && wdata_i[S_FLG0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= '0;
      en_q    <= 1'b0;
      ie_q    <= '0;
      mode_q  <= '0;
      start_q <= '0;
      flag_q  <= '0;
      eoc_q   <= '0;
      seq1_q  <= 1'b0;
      got0_q  <= 1'b0;
    end else begin
      for (int e = 0; e < 2; e++) begin
        if (!en_q || clr_st[e]) start_q[e] <= 1'b0;
        else if (set_st[e])     start_q[e] <= 1'b1;
        if (fset[e])            flag_q[e] <= 1'b1;
        else if (fclr[e])       flag_q[e] <= 1'b0;
        if (fin_i[e])                         eoc_q[e] <= 1'b1;
        else if (set_st[e] && !start_q[e])    eoc_q[e] <= 1'b0;
      end
      if (!en_q)                  seq1_q <= 1'b0;
      else if (sim && end_w[0])   seq1_q <= 1'b1;
      else if (end_w[1])          seq1_q <= 1'b0;
      if (!en_q)                  got0_q <= 1'b0;
      else if (sim && fin_i[0])   got0_q <= 1'b1;
      else if (end_w[1])          got0_q <= 1'b0;
      if (wr_mask) mask_q <= wdata_i;
      if (wr_ctrl) begin
        en_q   <= wdata_i[C_EN];
        ie_q   <= {wdata_i[C_IE1], wdata_i[C_IE0]};
        mode_q <= wdata_i[C_MODE +: 2];
      end
    end
  end

  assign run_o  = en_q;
  assign req_o  = {start_q[1], start_q[0] && !seq1_q};
  assign mask_o = mask_q[2*N-1:0];
  assign irq_o  = flag_q & ie_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr)
      A_MASK: rdata_o = mask_q;
      A_CTRL: begin
        rdata_o[C_EN]       = en_q;
        rdata_o[C_IE0]      = ie_q[0];
        rdata_o[C_ST0]      = start_q[0];
        rdata_o[C_MODE +: 2] = mode_q;
        rdata_o[C_IE1]      = ie_q[1];
        rdata_o[C_ST1]      = start_q[1];
      end
      A_STAT: begin
        rdata_o[S_FLG0]       = flag_q[0];
        rdata_o[S_BSY0]       = busy_i[0];
        rdata_o[S_CH0 +: CHW] = ch_i[0 +: CHW];
        rdata_o[S_FLG1]       = flag_q[1];
        rdata_o[S_BSY1]       = busy_i[1];
        rdata_o[S_CH1 +: CHW] = ch_i[CHW +: CHW];
        rdata_o[S_EOC0]       = eoc_q[0];
        rdata_o[S_EOC1]       = eoc_q[1];
      end
      A_DATA: begin
        rdata_o[0 +: W]  = res_i[0 +: W];
        rdata_o[HW +: W] = res_i[W +: W];
      end
      default: rdata_o = '0;
    endcase
  end

  // R3
  start_self_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i[1] |=> !start_q[1]);
  // R9
  sim_no_flag1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q[1]) |-> !$past(sim));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int N = NCH,
  parameter int W = DW,
  localparam int CHW = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic [1:0]       reg_addr_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  input  logic [1:0]       trig_i,
  output logic [1:0]       conv_start_o,
  output logic [2*CHW-1:0] conv_ch_o,
  input  logic [1:0]       conv_done_i,
  input  logic [2*W-1:0]   conv_data_i,
  output logic [1:0]       irq_o
);
  logic             run;
  logic [1:0]       req, busy, skip, fin;
  logic [2*N-1:0]   mask;
  logic [2*W-1:0]   res;

  adc_scan_regs #(.N(N), .W(W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .trig_i  (trig_i),
    .busy_i  (busy),
    .ch_i    (conv_ch_o),
    .res_i   (res),
    .skip_i  (skip),
    .fin_i   (fin),
    .run_o   (run),
    .req_o   (req),
    .mask_o  (mask),
    .irq_o   (irq_o),
    .rdata_o (reg_rdata_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_eng
    adc_scan_engine #(.N(N), .W(W)) u_eng (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .run_i        (run),
      .req_i        (req[g]),
      .mask_i       (mask[g*N +: N]),
      .conv_done_i  (conv_done_i[g]),
      .conv_data_i  (conv_data_i[g*W +: W]),
      .conv_start_o (conv_start_o[g]),
      .conv_ch_o    (conv_ch_o[g*CHW +: CHW]),
      .busy_o       (busy[g]),
      .skip_o       (skip[g]),
      .fin_o        (fin[g]),
      .result_o     (res[g*W +: W])
    );
  end

  // R2
  disable_idles_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run |=> (busy == 2'b00));
endmodule

// File: tb/adc_scan_seq_tb.sv
`timescale 1ns/1ps
module adc_scan_seq_tb;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wdata = '0;
  logic [1:0]  trig = '0;
  logic [1:0]  done_b = '0;
  logic [23:0] data_b = '0;
  logic [31:0] rdata;
  logic [1:0]  cstart, irq;
  logic [7:0]  cch;

  int checks = 0, errors = 0, cycles = 0, tick = 0;
  string cur_req = "R1";

  always #4 clk = ~clk;

  adc_scan_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .trig_i(trig),
    .conv_start_o(cstart), .conv_ch_o(cch), .conv_done_i(done_b),
    .conv_data_i(data_b), .irq_o(irq));

  // reference model state
  logic [31:0] m_mask;
  logic        m_en, m_seq1, m_got0;
  logic [1:0]  m_ie, m_mode, m_start, m_flag, m_eoc, m_busy, m_cst;
  logic [3:0]  m_ch [2];
  logic [15:0] m_scan [2];
  logic [11:0] m_res [2];
  // model temporaries
  logic        sim, wc, ws, wm;
  logic [1:0]  beg, skp, stp, fin, setv, clrv, fs;
  logic [15:0] mk [2];
  int          fst [2], nx [2];

  // stub state
  int cnt [2], pch [2];
  int seen0 [$];
  int seen1 [$];
  logic [11:0] last_data [2];

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [1:0] a);
    logic [31:0] v = '0;
    case (a)
      2'd0: v = m_mask;
      2'd1: begin v[0]=m_en; v[1]=m_ie[0]; v[3]=m_start[0]; v[7:6]=m_mode; v[9]=m_ie[1]; v[11]=m_start[1]; end
      2'd2: begin v[0]=m_flag[0]; v[3]=m_busy[0]; v[7:4]=m_ch[0]; v[8]=m_flag[1]; v[11]=m_busy[1];
                  v[15:12]=m_ch[1]; v[23]=m_eoc[0]; v[31]=m_eoc[1]; end
      default: begin v[11:0]=m_res[0]; v[27:16]=m_res[1]; end
    endcase
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mask = '0; m_en = 0; m_seq1 = 0; m_got0 = 0; m_ie = '0; m_mode = '0;
      m_start = '0; m_flag = '0; m_eoc = '0; m_busy = '0; m_cst = '0;
      for (int e = 0; e < 2; e++) begin m_ch[e] = '0; m_scan[e] = '0; m_res[e] = '0; end
    end else begin
      sim = m_mode[1];
      wc = we && addr == 2'd1; ws = we && addr == 2'd2; wm = we && addr == 2'd0;
      for (int e = 0; e < 2; e++) begin
        mk[e] = (e == 1) ? m_mask[31:16] : m_mask[15:0];
        fst[e] = -1; nx[e] = -1;
        for (int k = 0; k < 16; k++) begin
          if (mk[e][k] && fst[e] < 0) fst[e] = k;
          if (m_scan[e][k] && k > int'(m_ch[e]) && nx[e] < 0) nx[e] = k;
        end
        beg[e] = m_en && !m_busy[e] && m_start[e] && !(e == 0 && m_seq1) && fst[e] >= 0;
        skp[e] = m_en && !m_busy[e] && m_start[e] && !(e == 0 && m_seq1) && fst[e] < 0;
        stp[e] = m_en && m_busy[e] && done_b[e];
        fin[e] = stp[e] && nx[e] < 0;
      end
      setv[0] = m_en && (trig[0] || (wc && wdata[3]));
      setv[1] = sim ? (fin[0] || skp[0]) : (m_en && (trig[1] || (wc && wdata[11])));
      clrv[0] = sim ? (fin[1] || skp[1]) : (fin[0] || skp[0]);
      clrv[1] = fin[1] || skp[1];
      fs[0] = sim ? (fin[1] || (skp[1] && m_got0)) : fin[0];
      fs[1] = !sim && fin[1];
      for (int e = 0; e < 2; e++) begin
        if (fin[e]) m_eoc[e] = 1;
        else if (setv[e] && !m_start[e]) m_eoc[e] = 0;
        if (fs[e]) m_flag[e] = 1;
        else if (ws && wdata[e*8]) m_flag[e] = 0;
        if (!m_en || clrv[e]) m_start[e] = 0;
        else if (setv[e]) m_start[e] = 1;
        if (!m_en) begin m_busy[e] = 0; m_cst[e] = 0; end
        else begin
          m_cst[e] = 0;
          if (beg[e]) begin m_busy[e] = 1; m_ch[e] = 4'(fst[e]); m_scan[e] = mk[e]; m_cst[e] = 1; end
          else if (stp[e]) begin
            m_res[e] = data_b[e*12 +: 12];
            if (nx[e] >= 0) begin m_ch[e] = 4'(nx[e]); m_cst[e] = 1; end
            else m_busy[e] = 0;
          end
        end
      end
      if (!m_en) begin m_seq1 = 0; m_got0 = 0; end
      else begin
        if (sim && (fin[0] || skp[0])) m_seq1 = 1; else if (fin[1] || skp[1]) m_seq1 = 0;
        if (sim && fin[0]) m_got0 = 1; else if (fin[1] || skp[1]) m_got0 = 0;
      end
      if (wm) m_mask = wdata;
      if (wc) begin m_en = wdata[0]; m_ie = {wdata[9], wdata[1]}; m_mode = wdata[7:6]; end
    end
  end

  // per-cycle comparison, converter stub, watchdog
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      chk(cur_req, "rdata", rdata, mread(addr));
      chk(cur_req, "irq", {30'd0, irq}, {30'd0, m_flag & m_ie});
      chk(cur_req, "conv_start", {30'd0, cstart}, {30'd0, m_cst});
      chk(cur_req, "conv_ch", {24'd0, cch}, {24'd0, m_ch[1], m_ch[0]});
    end
    for (int e = 0; e < 2; e++) begin
      done_b[e] = 1'b0;
      if (cnt[e] > 0) begin
        cnt[e]--;
        if (cnt[e] == 0) begin
          done_b[e] = 1'b1;
          last_data[e] = 12'((tick * 37 + pch[e] * 113 + e * 2000) % 4096);
          data_b[e*12 +: 12] = last_data[e];
        end
      end
      if (cstart[e]) begin
        cnt[e] = LAT;
        pch[e] = int'(cch[e*4 +: 4]);
        if (e == 0) seen0.push_back(pch[e]); else seen1.push_back(pch[e]);
      end
    end
    tick++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); #1; we = 1; addr = a; wdata = d;
    @(negedge clk); #1; we = 0; addr = 2'd2;
  endtask
  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk); #1; addr = a; #1; v = rdata;
  endtask
  task automatic pulse(input logic [1:0] m);
    @(negedge clk); #1; trig = m;
    @(negedge clk); #1; trig = 2'b00;
  endtask
  task automatic chk_seq(input string tag, input int q [$], input int exp [$]);
    checks++;
    if (q != exp) begin
      errors++;
      $display("FAIL %s channel order actual=%p expected=%p", tag, q, exp);
    end
  endtask

  initial begin
    logic [31:0] v;
    idle(3); #1 rst_n = 1;
    // R1 reset state and mask layout
    rd(2'd0, v); chk("R1", "reset mask", v, 0);
    rd(2'd1, v); chk("R1", "reset ctrl", v, 0);
    rd(2'd2, v); chk("R1", "reset status", v, 0);
    wr(2'd0, 32'h00F0_00A5);
    rd(2'd0, v); chk("R1", "mask readback", v, 32'h00F0_00A5);
    // R2 disabled: no acceptance
    cur_req = "R2";
    pulse(2'b11); wr(2'd1, 32'h0000_0808); idle(10);
    rd(2'd1, v); chk("R2", "ctrl while disabled", v, 0);
    chk("R2", "no start while disabled", seen0.size() + seen1.size(), 0);
    // R3 R4 R5 R6 independent scan on engine 0
    cur_req = "R4";
    wr(2'd1, 32'h0000_0203);
    pulse(2'b01);
    rd(2'd1, v); chk("R3", "start bit set", v[3], 1);
    idle(40);
    chk_seq("R4", seen0, '{0, 2, 5, 7});
    rd(2'd2, v); chk("R5", "flag0/eoc0 set busy0 clear", v & 32'h0080_0009, 32'h0080_0001);
    chk("R6", "irq0", {30'd0, irq}, 32'd1);
    rd(2'd1, v); chk("R3", "start bit self-clear", v[3], 0);
    rd(2'd3, v); chk("R4", "last result", v[11:0], last_data[0]);
    cur_req = "R5";
    wr(2'd2, 32'h0000_0001);
    rd(2'd2, v); chk("R5", "flag0 w1c", v[0], 0);
    chk("R6", "irq0 off", {30'd0, irq}, 0);
    // R10 software start engine 1
    cur_req = "R10";
    wr(2'd1, 32'h0000_0A03); idle(40);
    chk_seq("R10", seen1, '{4, 5, 6, 7});
    rd(2'd2, v); chk("R10", "flag1/eoc1", v & 32'h8000_0100, 32'h8000_0100);
    chk("R6", "irq1", {30'd0, irq}, 32'd2);
    // R7 retrigger during scan
    cur_req = "R7";
    seen0.delete();
    pulse(2'b01); idle(2); pulse(2'b01); wr(2'd1, 32'h0000_0209); idle(50);
    chk("R7", "single scan", seen0.size(), 4);
    // R8 empty mask
    cur_req = "R8";
    seen0.delete();
    wr(2'd0, 32'h00F0_0000); wr(2'd2, 32'h0000_0101);
    pulse(2'b01); idle(5);
    rd(2'd1, v); chk("R8", "start cleared", v[3], 0);
    rd(2'd2, v); chk("R8", "no flag0 no eoc0", v & 32'h0080_0001, 0);
    chk("R8", "no conversion", seen0.size(), 0);
    // R9 simultaneous mode 10
    cur_req = "R9";
    seen0.delete(); seen1.delete();
    wr(2'd0, 32'h00F0_00A5); wr(2'd1, 32'h0000_0283);
    pulse(2'b10); wr(2'd1, 32'h0000_0A83); idle(10);
    chk("R9", "engine1 trigger ignored", seen1.size(), 0);
    pulse(2'b01); idle(3);
    rd(2'd1, v); chk("R9", "start0 held", v[3], 1);
    idle(80);
    chk_seq("R9", seen0, '{0, 2, 5, 7});
    chk_seq("R9", seen1, '{4, 5, 6, 7});
    rd(2'd2, v); chk("R9", "only flag0", v & 32'h0000_0101, 32'h0000_0001);
    rd(2'd1, v); chk("R9", "starts cleared", v & 32'h0000_0808, 0);
    // R9 mode 11 with engine 0 empty
    wr(2'd2, 32'h0000_0101); wr(2'd0, 32'h00F0_0000); wr(2'd1, 32'h0000_02C3);
    pulse(2'b01); idle(40);
    rd(2'd2, v); chk("R9", "mode11 only flag0", v & 32'h0000_0101, 32'h0000_0001);
    // R10 reserved mode 01 independent
    cur_req = "R10";
    seen0.delete(); seen1.delete();
    wr(2'd2, 32'h0000_0101); wr(2'd1, 32'h0000_0243);
    pulse(2'b10); idle(40);
    rd(2'd2, v); chk("R10", "mode01 flag1 only", v & 32'h0000_0101, 32'h0000_0100);
    chk("R10", "engine0 idle", seen0.size(), 0);
    // R2 abort
    cur_req = "R2";
    wr(2'd0, 32'hFFFF_FFFF);
    pulse(2'b01); idle(6);
    wr(2'd1, 32'h0000_0000);
    rd(2'd2, v); chk("R2", "abort busy0", v[3], 0);
    rd(2'd1, v); chk("R2", "abort ctrl", v, 0);
    idle(10);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule